// File: doc/BRIEF.md
# Interrupt Controller Register Block

This block gathers 64 interrupt sources into two request outputs, one for ordinary handling and one for fast handling. Each source is either level-sensitive or edge-sensitive. Level sources follow their synchronized input. Edge sources capture a selected transition in a sticky per-source latch that software clears by writing a one. A software trigger can also raise any source. Each source has an enable and a routing bit, and together these decide which output, if either, the source asserts.

Software reaches the block over a single-cycle bus of the APB kind. A write takes effect on the clock edge where select, enable and write are all high. A read is combinational from the address while select is high. The sources are held as a low word (sources 0 to 31) and a high word (sources 32 to 63). Every high-word register sits 4 bytes above its low-word counterpart, so address bit 2 picks the word and address bits 6:3 pick the register. Enables and soft triggers each have a register that sets bits and a separate register that clears them. Bits written as zero leave their sources alone.

Top module: `intc_regs`

## Requirements
- R1: After reset, the enable, soft-trigger, routing and edge-latch bits are all zero and both outputs are low. Sense, event-polarity and dual-edge bits start at their parameter values (defaults: sense `0xFFFFFFFF` in the high word and 0 in the low word, event all ones, dual 0), and each of them can be rewritten afterwards.
- R2: Writing ones to offset 0x20 sets those enable bits, and writing ones to 0x28 clears them. Zero bits leave other sources unchanged. A read of either offset returns the enable word.
- R3: Writing ones to 0x30 sets software triggers, and writing ones to 0x38 clears them. A read of either offset returns the trigger word. A set trigger makes the source's raw status 1.
- R4: A source with routing bit 0 (offset 0x18) appears in the normal status (0x00) and drives the normal output. A source with routing bit 1 appears in the fast status (0x08) and drives the fast output. Both require the source to be enabled and raw-active. Each output is the OR of its status word.
- R5: A source with sense bit 1 (offset 0x40) is level-triggered. Its raw status (offset 0x10) follows the input level after the two-flop synchronizer.
- R6: A source with sense bit 0 is edge-triggered. Its latch (read at 0x60) sets on a rising input edge when its event bit (0x50) is 1 and on a falling edge when that bit is 0. The latch stays set after the input returns.
- R7: When the source's dual-edge bit (0x48) is 1, either input edge sets its latch.
- R8: Writing a one to an edge-clear bit (0x58) clears that latch. Zero bits leave other latches set. Clearing a level-sensitive source does not change its raw status.
- R9: If an edge is detected in the same cycle as a clear write to that source, the latch ends set.
- R10: Reading any register changes no state.
- R11: High-word registers sit at the low-word offset plus 4. Offset 0x58/0x5C reads as zero, and so do addresses above 0x64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Bus select |
| bus_en | input | 1 | Bus access phase |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| src_in | input | 64 | Asynchronous interrupt source inputs |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_fast_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is the collision in R9, where a clear write and a freshly detected edge on the same source land on the same clock. The stimulus changes the input at a falling clock edge and then waits exactly two cycles, the synchronizer depth. It then issues the clear write, so that the write commits on the edge where the edge detector fires. A sweep across all 64 sources then checks routing, status words and outputs for each source driven alone by its soft trigger.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int RI_NORM  = 0;
  localparam int RI_FAST  = 1;
  localparam int RI_RAW   = 2;
  localparam int RI_SEL   = 3;
  localparam int RI_ENSET = 4;
  localparam int RI_ENCLR = 5;
  localparam int RI_TSET  = 6;
  localparam int RI_TCLR  = 7;
  localparam int RI_SENSE = 8;
  localparam int RI_DUAL  = 9;
  localparam int RI_EVENT = 10;
  localparam int RI_ECLR  = 11;
  localparam int RI_LATCH = 12;

  // per-bit transition match: dual picks any change, else event picks rise(1)/fall(0)
  function automatic logic [31:0] edge_match(input logic [31:0] cur, input logic [31:0] prev,
                                             input logic [31:0] evt, input logic [31:0] dual);
    edge_match = (dual & (cur ^ prev)) |
                 (~dual & evt & cur & ~prev) |
                 (~dual & ~evt & ~cur & prev);
  endfunction

  // raw: level input for level sources, latch for edge sources, plus soft trigger
  function automatic logic [31:0] raw_calc(input logic [31:0] lvl, input logic [31:0] latch,
                                           input logic [31:0] sense, input logic [31:0] trig);
    raw_calc = (sense & lvl) | (~sense & latch) | trig;
  endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_out  <= '0;
    end else begin
      stage1 <= d_in;
      q_out  <= stage1;
    end
  end
endmodule

// File: rtl/intc_word.sv
module intc_word
  import intc_pkg::*;
#(
  parameter int          W         = 32,
  parameter logic [31:0] SENSE_RST = '0,
  parameter logic [31:0] EVENT_RST = '1,
  parameter logic [31:0] DUAL_RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] wdata,
  input  logic         we_sel,
  input  logic         we_enset,
  input  logic         we_enclr,
  input  logic         we_tset,
  input  logic         we_tclr,
  input  logic         we_sense,
  input  logic         we_dual,
  input  logic         we_event,
  input  logic         we_eclr,
  output logic [W-1:0] sel_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] trig_q,
  output logic [W-1:0] sense_q,
  output logic [W-1:0] dual_q,
  output logic [W-1:0] event_q,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] norm_o,
  output logic [W-1:0] fast_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] hit_w;      // qualified edge events on edge sources
  logic [W-1:0] clr_w;      // clear requests on edge sources
  logic [W-1:0] en_set_w;
  logic [W-1:0] en_clr_w;
  logic [W-1:0] t_clr_w;

  assign hit_w    = edge_match(lvl_i, prev_q, event_q, dual_q) & ~sense_q;
  assign clr_w    = (we_eclr ? wdata : '0) & ~sense_q;
  assign en_set_w = we_enset ? wdata : '0;
  assign en_clr_w = we_enclr ? wdata : '0;
  assign t_clr_w  = we_tclr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      sel_q   <= '0;
      en_q    <= '0;
      trig_q  <= '0;
      latch_q <= '0;
      sense_q <= SENSE_RST;
      dual_q  <= DUAL_RST;
      event_q <= EVENT_RST;
    end else begin
      prev_q  <= lvl_i;
      if (we_sel)   sel_q   <= wdata;
      if (we_sense) sense_q <= wdata;
      if (we_dual)  dual_q  <= wdata;
      if (we_event) event_q <= wdata;
      en_q    <= (en_q | en_set_w) & ~en_clr_w;
      trig_q  <= (trig_q | (we_tset ? wdata : '0)) & ~t_clr_w;
      latch_q <= (latch_q & ~clr_w) | hit_w;   // new edge wins over clear
    end
  end

  assign raw_o  = raw_calc(lvl_i, latch_q, sense_q, trig_q);
  assign norm_o = raw_o & en_q & ~sel_q;
  assign fast_o = raw_o & en_q & sel_q;

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(hit_w)) == $past(hit_w)));                          // R6
  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latch_q & $past(clr_w & ~hit_w)) == '0));                          // R8
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en_q & $past(en_set_w & ~en_clr_w)) == $past(en_set_w & ~en_clr_w))); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((en_q & $past(en_clr_w)) == '0));                                   // R2
  AST_TRIG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((trig_q & $past(t_clr_w)) == '0));                                  // R3
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          ADDR_W    = 7,
  parameter logic [63:0] SENSE_RST = 64'hFFFF_FFFF_0000_0000,
  parameter logic [63:0] EVENT_RST = 64'hFFFF_FFFF_FFFF_FFFF,
  parameter logic [63:0] DUAL_RST  = 64'h0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_en,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [2*WORD_W-1:0] src_in,
  output logic                irq_norm_o,
  output logic                irq_fast_o
);
  localparam int NWORDS = 2;
  localparam int NSRC   = NWORDS * WORD_W;

  logic [NSRC-1:0] lvl_w;
  logic            wr_w;
  logic            half_w;
  logic [3:0]      ri_w;

  logic [WORD_W-1:0] sel_v [NWORDS];
  logic [WORD_W-1:0] en_v [NWORDS];
  logic [WORD_W-1:0] trig_v [NWORDS];
  logic [WORD_W-1:0] sense_v [NWORDS];
  logic [WORD_W-1:0] dual_v [NWORDS];
  logic [WORD_W-1:0] event_v [NWORDS];
  logic [WORD_W-1:0] latch_v [NWORDS];
  logic [WORD_W-1:0] raw_v [NWORDS];
  logic [WORD_W-1:0] norm_v [NWORDS];
  logic [WORD_W-1:0] fast_v [NWORDS];

  assign wr_w   = bus_sel & bus_en & bus_wr;
  assign half_w = bus_addr[2];
  assign ri_w   = bus_addr[6:3];

  intc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(src_in), .q_out(lvl_w)
  );

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic hit_g;
    assign hit_g = wr_w && (half_w == g[0]);
    intc_word #(
      .W(WORD_W),
      .SENSE_RST(SENSE_RST[g*WORD_W +: WORD_W]),
      .EVENT_RST(EVENT_RST[g*WORD_W +: WORD_W]),
      .DUAL_RST(DUAL_RST[g*WORD_W +: WORD_W])
    ) u_word (
      .clk(clk), .rst_n(rst_n),
      .lvl_i(lvl_w[g*WORD_W +: WORD_W]),
      .wdata(bus_wdata),
      .we_sel(hit_g && ri_w == 4'(RI_SEL)),
      .we_enset(hit_g && ri_w == 4'(RI_ENSET)),
      .we_enclr(hit_g && ri_w == 4'(RI_ENCLR)),
      .we_tset(hit_g && ri_w == 4'(RI_TSET)),
      .we_tclr(hit_g && ri_w == 4'(RI_TCLR)),
      .we_sense(hit_g && ri_w == 4'(RI_SENSE)),
      .we_dual(hit_g && ri_w == 4'(RI_DUAL)),
      .we_event(hit_g && ri_w == 4'(RI_EVENT)),
      .we_eclr(hit_g && ri_w == 4'(RI_ECLR)),
      .sel_q(sel_v[g]), .en_q(en_v[g]), .trig_q(trig_v[g]),
      .sense_q(sense_v[g]), .dual_q(dual_v[g]), .event_q(event_v[g]),
      .latch_q(latch_v[g]), .raw_o(raw_v[g]), .norm_o(norm_v[g]), .fast_o(fast_v[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (int'(ri_w))
        RI_NORM:            bus_rdata = norm_v[half_w];
        RI_FAST:            bus_rdata = fast_v[half_w];
        RI_RAW:             bus_rdata = raw_v[half_w];
        RI_SEL:             bus_rdata = sel_v[half_w];
        RI_ENSET, RI_ENCLR: bus_rdata = en_v[half_w];
        RI_TSET, RI_TCLR:   bus_rdata = trig_v[half_w];
        RI_SENSE:           bus_rdata = sense_v[half_w];
        RI_DUAL:            bus_rdata = dual_v[half_w];
        RI_EVENT:           bus_rdata = event_v[half_w];
        RI_LATCH:           bus_rdata = latch_v[half_w];
        default:            bus_rdata = '0;
      endcase
    end
  end

  assign irq_norm_o = |{norm_v[1], norm_v[0]};
  assign irq_fast_o = |{fast_v[1], fast_v[0]};

  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ((norm_v[0] & fast_v[0]) == '0) && ((norm_v[1] & fast_v[1]) == '0));                    // R4
  AST_STATUS_IN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (((norm_v[0] | fast_v[0]) & ~raw_v[0]) == '0) && (((norm_v[1] | fast_v[1]) & ~raw_v[1]) == '0)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_norm_o && !irq_fast_o));                                          // R1
endmodule

// File: tb/intc_regs_test.sv
module intc_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq_norm_o, irq_fast_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; commits on the next rising edge
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0; bus_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, {32'h0, d}, {32'h0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d1, d2;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    check("R1 outputs", {62'h0, irq_norm_o, irq_fast_o}, 64'h0);
    rdchk("R1 enable lo", 7'h20, 32'h0);
    rdchk("R1 enable hi", 7'h24, 32'h0);
    rdchk("R1 select", 7'h18, 32'h0);
    rdchk("R1 trigger", 7'h30, 32'h0);
    rdchk("R1 latch lo", 7'h60, 32'h0);
    rdchk("R1 sense lo", 7'h40, 32'h0);
    rdchk("R1 sense hi", 7'h44, 32'hFFFF_FFFF);
    rdchk("R1 event hi", 7'h54, 32'hFFFF_FFFF);
    rdchk("R1 dual lo", 7'h48, 32'h0);

    // R2 enable set/clear and R11 word offsets
    wr(7'h20, 32'h0000_00F5);
    rdchk("R2 enset", 7'h20, 32'h0000_00F5);
    wr(7'h20, 32'h0000_0100);
    rdchk("R2 enset keeps others", 7'h20, 32'h0000_01F5);
    wr(7'h28, 32'h0000_0005);
    rdchk("R2 enclr", 7'h28, 32'h0000_01F0);
    wr(7'h24, 32'hA000_0000);
    rdchk("R11 high enable", 7'h24, 32'hA000_0000);
    rdchk("R11 low untouched", 7'h20, 32'h0000_01F0);
    wr(7'h20, 32'hFFFF_FFFF);
    wr(7'h24, 32'hFFFF_FFFF);

    // R3/R4 sweep over all 64 sources, each raised alone by soft trigger
    for (int i = 0; i < 64; i++) begin
      logic        fast;
      logic [6:0]  off;
      logic [31:0] bitv, sn, sf, sr;
      fast = (i % 3) == 1;
      off  = (i >= 32) ? 7'h4 : 7'h0;
      bitv = 32'h1 << (i % 32);
      wr(7'h18 + off, fast ? bitv : 32'h0);
      wr(7'h30 + off, bitv);
      rd(7'h00 + off, sn);
      rd(7'h08 + off, sf);
      rd(7'h10 + off, sr);
      check($sformatf("R4 route src %0d", i),
            {irq_norm_o, irq_fast_o, sn, sr[29:0]},
            {!fast, fast, (fast ? 32'h0 : bitv), bitv[29:0]});
      check($sformatf("R4 fast status src %0d", i), {32'h0, sf}, {32'h0, fast ? bitv : 32'h0});
      wr(7'h38 + off, bitv);
      rd(7'h30 + off, sr);
      check($sformatf("R3 trig clear src %0d", i), {30'h0, irq_norm_o, irq_fast_o, sr}, 64'h0);
      wr(7'h18 + off, 32'h0);
    end

    // R5 level source 40 (high word bit 8)
    src_in[40] = 1'b1;
    tick(3);
    rdchk("R5 level high raw", 7'h14, 32'h0000_0100);
    check("R5 level drives normal", {63'h0, irq_norm_o}, 64'h1);
    rdchk("R5 level no latch", 7'h64, 32'h0);

    // R8 clear on a level source has no effect
    wr(7'h5C, 32'hFFFF_FFFF);
    rdchk("R8 level clear ignored", 7'h14, 32'h0000_0100);
    src_in[40] = 1'b0;
    tick(3);
    rdchk("R5 level low raw", 7'h14, 32'h0);

    // R6 rising edge on source 3
    src_in[3] = 1'b1;
    tick(4);
    rdchk("R6 rising latched", 7'h60, 32'h0000_0008);
    src_in[3] = 1'b0;
    tick(4);
    rdchk("R6 latch sticky", 7'h60, 32'h0000_0008);
    wr(7'h58, 32'h0000_0008);
    rdchk("R8 clear latch", 7'h60, 32'h0);
    // R6 falling polarity
    wr(7'h50, 32'hFFFF_FFF7);
    src_in[3] = 1'b1;
    tick(4);
    rdchk("R6 rise ignored when falling", 7'h60, 32'h0);
    src_in[3] = 1'b0;
    tick(4);
    rdchk("R6 falling latched", 7'h60, 32'h0000_0008);

    // R7 dual edge on source 5
    wr(7'h48, 32'h0000_0020);
    src_in[5] = 1'b1;
    tick(4);
    rdchk("R7 dual rise", 7'h60, 32'h0000_0028);
    // R8 partial clear: bit 5 only, bit 3 stays
    wr(7'h58, 32'h0000_0020);
    rdchk("R8 zero bits keep", 7'h60, 32'h0000_0008);
    src_in[5] = 1'b0;
    tick(4);
    rdchk("R7 dual fall", 7'h60, 32'h0000_0028);
    wr(7'h58, 32'hFFFF_FFFF);
    rdchk("R8 clear all", 7'h60, 32'h0);

    // R9 edge arrives on the clock where the clear commits (source 7)
    src_in[7] = 1'b1;
    tick(2);
    wr(7'h58, 32'h0000_0080);
    tick(1);
    rdchk("R9 edge beats clear", 7'h60, 32'h0000_0080);

    // R10 reads have no side effects
    rd(7'h60, d1);
    rd(7'h10, d2);
    rd(7'h60, d1);
    rd(7'h00, d2);
    tick(1);
    rdchk("R10 latch after reads", 7'h60, 32'h0000_0080);
    rdchk("R10 raw after reads", 7'h10, 32'h0000_0080);
    check("R10 output after reads", {63'h0, irq_norm_o}, 64'h1);

    // R11 unmapped and write-only offsets read zero
    rdchk("R11 clear reads zero", 7'h5C, 32'h0);
    rdchk("R11 above map", 7'h68, 32'h0);
    rdchk("R11 top of space", 7'h7C, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule